// File: doc/BRIEF.md
# Peripheral Pad Owner with Sleep Hold

The block decides, pin by pin, who drives a bank of 22 peripheral pads. A pad whose peripheral lane is enabled passes that peripheral's output and output-enable through unchanged. A pad whose lane is disabled is owned by the block and behaves as a plain general-purpose pin. Its direction and output level come from two registers, and its input level can be read back through a two-flop synchroniser. Owned pins have no edge detection and raise no interrupt. The first twelve pads share one lane enable, which serves a parallel display unit. Each of the remaining ten pads has its own lane, so a serial unit's transmit and receive pins can be released separately.

For low power there is a sleep direction register, one bit per pad, that no reset clears. While the chip sleeps, every pad takes the direction in that register, and pads marked as outputs are driven low. Entering sleep also sets a hold flag. After wake the pads keep their sleep state until software writes a one to the hold flag, and only then do the peripherals and the general-purpose registers get the pads back.

Top module: `pad_owner_ctl`

## Requirements
- R1: After `rst_n` is sampled low, the direction and output registers read 0, the hold flag reads 0, the sleep state is cleared, and every block-owned pad has `pad_oe` = 0.
- R2: Pads 0..11 belong to lane 0, and pad 12+k belongs to lane 1+k. When a pad's lane enable is 1, `pad_oe`/`pad_out` equal `per_oe`/`per_out` for that pad. When it is 0, they equal the direction/output register bits. This applies only when the pads are not forced (R6, R7).
- R3: A write to address 0 loads the direction register (1 = output) and a write to address 1 loads the output register. Each takes effect on the cycle after the write, and each reads back at the same address.
- R4: A read of address 2 returns `pad_in` delayed by two clock edges. Writes to address 2 change nothing.
- R5: A write to address 3 loads the sleep direction register, which reads back at address 3 and is not cleared by `rst_n`.
- R6: While asleep, every pad has `pad_oe` equal to its sleep direction bit and `pad_out` = 0, whatever the lane enables, the peripheral inputs or the general-purpose registers hold.
- R7: A `sleep_enter` pulse makes the block asleep and sets the hold flag (bit 0 of address 4) on the next cycle. A `wake` pulse ends sleep, but the pads stay as in R6 while the hold flag is 1.
- R8: Writing a 1 to bit 0 of address 4 while awake clears the hold flag and returns the pads to R2 behaviour on the next cycle. Writing 0 has no effect. Writing 1 while asleep, including in the cycle of `wake`, is ignored.
- R9: When `sleep_enter` and `wake` are both high in one cycle, the block is asleep afterwards.
- R10: Reads of addresses 5 to 7 return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 22 | Write data |
| bus_rdata | output | 22 | Read data for `bus_addr` (combinational) |
| lane_en | input | 11 | Peripheral lane enables |
| per_out | input | 22 | Peripheral output levels |
| per_oe | input | 22 | Peripheral output enables |
| sleep_enter | input | 1 | Pulse: enter sleep |
| wake | input | 1 | Pulse: leave sleep |
| pad_out | output | 22 | Pad output level |
| pad_oe | output | 22 | Pad output enable |
| pad_in | input | 22 | Pad input level |

## Verification
The hardest state to reach is the window after wake in which the hold flag is still set, because only a chain of events gets the block there. The stimulus loads a sleep direction pattern and enters sleep. It then tries to clear the hold flag both while asleep and in the same cycle as `wake`, and writes a zero to it after wake. Only after all of that does a one-write release the pads. A second path pulses `rst_n` between two sleeps to show that the sleep direction pattern survives while the hold flag is cleared. A cycle where `sleep_enter` and `wake` coincide is also driven.

// File: rtl/pad_owner_pkg.sv
// Package: register addresses shared by the pad owner block and its bench.
// Assumes a 3-bit register address bus.
package pad_owner_pkg;
    localparam int ADDR_W = 3;

    typedef enum logic [ADDR_W-1:0] {
        RA_DIR  = 3'd0,
        RA_OUT  = 3'd1,
        RA_IN   = 3'd2,
        RA_SDIR = 3'd3,
        RA_HOLD = 3'd4
    } reg_addr_e;
endpackage

// File: rtl/pad_in_sync.sv
// Two-flop synchroniser for the pad input levels.
// Assumes the pad inputs are asynchronous to clk; both stages reset to 0.
module pad_in_sync #(
    parameter int W = 22
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    logic [W-1:0] stage1_q, stage2_q;

    // Shift the pad levels through two flops.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage1_q <= '0;
            stage2_q <= '0;
        end else begin
            stage1_q <= din;
            stage2_q <= stage1_q;
        end
    end

    assign dout = stage2_q;
endmodule

// File: rtl/pad_regfile.sv
// Register file for the pad owner: general-purpose direction and output,
// sleep direction (never reset), and the sleep / hold state.
// Assumes single-cycle writes and combinational reads.
module pad_regfile
    import pad_owner_pkg::*;
#(
    parameter int NPINS = 22
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic [ADDR_W-1:0] addr,
    input  logic [NPINS-1:0]  wdata,
    output logic [NPINS-1:0]  rdata,
    input  logic [NPINS-1:0]  sync_in,
    input  logic              sleep_enter,
    input  logic              wake,
    output logic [NPINS-1:0]  gp_dir,
    output logic [NPINS-1:0]  gp_out,
    output logic [NPINS-1:0]  sleep_dir,
    output logic              forced
);
    logic [NPINS-1:0] dir_q, out_q, sdir_q;
    logic             asleep_q, hold_q;
    logic             hold_w1;

    assign hold_w1 = wr && (addr == RA_HOLD) && wdata[0];

    // General-purpose direction and output registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dir_q <= '0;
            out_q <= '0;
        end else if (wr) begin
            if (addr == RA_DIR) dir_q <= wdata;
            if (addr == RA_OUT) out_q <= wdata;
        end
    end

    // Sleep direction register; deliberately outside every reset.
    always_ff @(posedge clk) begin
        if (wr && (addr == RA_SDIR)) sdir_q <= wdata;
    end

    // Sleep state and hold flag; sleep entry wins over wake and clearing.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            asleep_q <= 1'b0;
            hold_q   <= 1'b0;
        end else if (sleep_enter) begin
            asleep_q <= 1'b1;
            hold_q   <= 1'b1;
        end else begin
            if (wake) asleep_q <= 1'b0;
            if (hold_w1 && !asleep_q) hold_q <= 1'b0;
        end
    end

    // Read multiplexer.
    always_comb begin
        case (addr)
            RA_DIR:  rdata = dir_q;
            RA_OUT:  rdata = out_q;
            RA_IN:   rdata = sync_in;
            RA_SDIR: rdata = sdir_q;
            RA_HOLD: rdata = {{(NPINS-1){1'b0}}, hold_q};
            default: rdata = '0;
        endcase
    end

    assign gp_dir    = dir_q;
    assign gp_out    = out_q;
    assign sleep_dir = sdir_q;
    assign forced    = asleep_q | hold_q;

    assert_hold_in_sleep_R7: assert property (@(posedge clk) disable iff (!rst_n)
        asleep_q |-> hold_q);
    assert_enter_sets_R7: assert property (@(posedge clk) disable iff (!rst_n)
        sleep_enter |=> (asleep_q && hold_q));
    assert_w0_keeps_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (hold_q && !hold_w1) |=> hold_q);
    assert_asleep_w1_ignored_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (asleep_q && hold_w1) |=> hold_q);
    assert_enter_beats_wake_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (sleep_enter && wake) |=> asleep_q);
    assert_dir_only_on_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr && addr == RA_DIR) |=> $stable(dir_q));
endmodule

// File: rtl/pad_pin_mux.sv
// Per-pad ownership multiplexer: sleep/hold forcing, then peripheral or
// general-purpose control. Pads below SHARED use lane 0; each pad above
// has a lane of its own.
module pad_pin_mux #(
    parameter int NPINS  = 22,
    parameter int SHARED = 12,
    parameter int NLANES = NPINS - SHARED + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NLANES-1:0] lane_en,
    input  logic [NPINS-1:0]  per_out,
    input  logic [NPINS-1:0]  per_oe,
    input  logic [NPINS-1:0]  gp_dir,
    input  logic [NPINS-1:0]  gp_out,
    input  logic [NPINS-1:0]  sleep_dir,
    input  logic              forced,
    output logic [NPINS-1:0]  pad_out,
    output logic [NPINS-1:0]  pad_oe
);
    for (genvar i = 0; i < NPINS; i++) begin : g_pin
        localparam int LANE = (i < SHARED) ? 0 : i - SHARED + 1;

        // Choose the pad's driver by priority: sleep, owner lane, registers.
        always_comb begin
            if (forced) begin
                pad_oe[i]  = sleep_dir[i];
                pad_out[i] = 1'b0;
            end else if (lane_en[LANE]) begin
                pad_oe[i]  = per_oe[i];
                pad_out[i] = per_out[i];
            end else begin
                pad_oe[i]  = gp_dir[i];
                pad_out[i] = gp_out[i];
            end
        end
    end

    assert_forced_low_R6: assert property (@(posedge clk) disable iff (!rst_n)
        forced |-> (pad_out == '0));
endmodule

// File: rtl/pad_owner_ctl.sv
// Top of the peripheral pad owner: register file, input synchroniser and
// per-pad multiplexer. Assumes synchronous active-low reset on clk.
module pad_owner_ctl
    import pad_owner_pkg::*;
#(
    parameter  int NPINS  = 22,
    parameter  int SHARED = 12,
    localparam int NLANES = NPINS - SHARED + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [NPINS-1:0]  bus_wdata,
    output logic [NPINS-1:0]  bus_rdata,
    input  logic [NLANES-1:0] lane_en,
    input  logic [NPINS-1:0]  per_out,
    input  logic [NPINS-1:0]  per_oe,
    input  logic              sleep_enter,
    input  logic              wake,
    output logic [NPINS-1:0]  pad_out,
    output logic [NPINS-1:0]  pad_oe,
    input  logic [NPINS-1:0]  pad_in
);
    logic [NPINS-1:0] sync_in, gp_dir, gp_out, sleep_dir;
    logic             forced;

    pad_in_sync #(.W(NPINS)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (pad_in),
        .dout (sync_in)
    );

    pad_regfile #(.NPINS(NPINS)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr         (bus_wr),
        .addr       (bus_addr),
        .wdata      (bus_wdata),
        .rdata      (bus_rdata),
        .sync_in    (sync_in),
        .sleep_enter(sleep_enter),
        .wake       (wake),
        .gp_dir     (gp_dir),
        .gp_out     (gp_out),
        .sleep_dir  (sleep_dir),
        .forced     (forced)
    );

    pad_pin_mux #(.NPINS(NPINS), .SHARED(SHARED), .NLANES(NLANES)) u_mux (
        .clk      (clk),
        .rst_n    (rst_n),
        .lane_en  (lane_en),
        .per_out  (per_out),
        .per_oe   (per_oe),
        .gp_dir   (gp_dir),
        .gp_out   (gp_out),
        .sleep_dir(sleep_dir),
        .forced   (forced),
        .pad_out  (pad_out),
        .pad_oe   (pad_oe)
    );
endmodule

// File: tb/pad_owner_ctl_bench.sv
// Bench: behavioural reference model stepped on every clock edge and
// compared with all outputs 2 ns after each edge.
module pad_owner_ctl_bench;
    localparam int NPINS  = 22;
    localparam int SHARED = 12;
    localparam int NLANES = NPINS - SHARED + 1;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic              rst_n = 1'b0;
    logic              bus_wr = 1'b0;
    logic [2:0]        bus_addr = '0;
    logic [NPINS-1:0]  bus_wdata = '0;
    logic [NPINS-1:0]  bus_rdata;
    logic [NLANES-1:0] lane_en = '0;
    logic [NPINS-1:0]  per_out = '0, per_oe = '0;
    logic              sleep_enter = 1'b0, wake = 1'b0;
    logic [NPINS-1:0]  pad_out, pad_oe;
    logic [NPINS-1:0]  pad_in = '0;

    pad_owner_ctl u_pad_owner_ctl (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .lane_en(lane_en),
        .per_out(per_out), .per_oe(per_oe), .sleep_enter(sleep_enter),
        .wake(wake), .pad_out(pad_out), .pad_oe(pad_oe), .pad_in(pad_in)
    );

    int    n_tests = 0, n_fail = 0;
    string cur_req = "R1";
    bit    started = 0, done = 0;

    // Reference model state.
    logic [NPINS-1:0] m_dir, m_out, m_sdir, m_s1, m_s2;
    bit               m_sleep, m_hold;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_dir = '0; m_out = '0; m_s1 = '0; m_s2 = '0;
            m_sleep = 0; m_hold = 0;
        end else begin
            m_s2 = m_s1;
            m_s1 = pad_in;
            if (bus_wr && bus_addr == 3'd0) m_dir = bus_wdata;
            if (bus_wr && bus_addr == 3'd1) m_out = bus_wdata;
            if (sleep_enter) begin
                m_sleep = 1; m_hold = 1;
            end else begin
                if (bus_wr && bus_addr == 3'd4 && bus_wdata[0] && !m_sleep) m_hold = 0;
                if (wake) m_sleep = 0;
            end
        end
        if (bus_wr && bus_addr == 3'd3) m_sdir = bus_wdata;
        started = 1;
    end

    task automatic check(input string tag, input string what,
                         input logic [NPINS-1:0] act, input logic [NPINS-1:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s actual %h expected %h", tag, what, act, exp);
        end
    endtask

    // Compare every output against the model after each edge.
    always @(posedge clk) begin
        logic [NPINS-1:0] e_oe, e_out, e_rd;
        #2;
        if (started && !done) begin
            for (int i = 0; i < NPINS; i++) begin
                int ln;
                ln = (i < SHARED) ? 0 : i - SHARED + 1;
                if (m_sleep || m_hold) begin
                    e_oe[i] = m_sdir[i]; e_out[i] = 1'b0;
                end else if (lane_en[ln]) begin
                    e_oe[i] = per_oe[i]; e_out[i] = per_out[i];
                end else begin
                    e_oe[i] = m_dir[i]; e_out[i] = m_out[i];
                end
            end
            case (bus_addr)
                3'd0: e_rd = m_dir;
                3'd1: e_rd = m_out;
                3'd2: e_rd = m_s2;
                3'd3: e_rd = m_sdir;
                3'd4: e_rd = {{(NPINS-1){1'b0}}, m_hold};
                default: e_rd = '0;
            endcase
            check(cur_req, "pad_oe", pad_oe, e_oe);
            check(cur_req, "pad_out", pad_out, e_out);
            check(cur_req, "bus_rdata", bus_rdata, e_rd);
        end
    end

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [2:0] a, input logic [NPINS-1:0] d);
        @(negedge clk);
        bus_wr = 1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 0;
    endtask

    task automatic rd(input logic [2:0] a);
        @(negedge clk);
        bus_addr = a;
        @(negedge clk);
    endtask

    task automatic finish_run;
        done = 1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_tests++; n_fail++;
        $display("FAIL watchdog expired in %s", cur_req);
        finish_run();
    end

    initial begin
        // R1: reset state
        idle(3); rst_n = 1;
        cur_req = "R1"; rd(3'd0); rd(3'd1); rd(3'd4);
        // R5: load sleep directions early so nothing reads them unset
        cur_req = "R5"; wr(3'd3, 22'h2A5A5A); rd(3'd3);
        // R3: general-purpose registers
        cur_req = "R3"; wr(3'd0, 22'h3F0F0F); rd(3'd0);
        wr(3'd1, 22'h155555); rd(3'd1); wr(3'd0, 22'h3FFFFF);
        // R2: lane ownership under several patterns
        cur_req = "R2";
        for (int k = 0; k < 8; k++) begin
            @(negedge clk);
            lane_en = (k == 0) ? '1 : (k == 1) ? 11'h555 : (k == 2) ? 11'h001 : NLANES'($urandom);
            per_out = NPINS'($urandom); per_oe = NPINS'($urandom);
        end
        // R4: synchronised readback; write to input address ignored
        cur_req = "R4"; bus_addr = 3'd2;
        for (int k = 0; k < 6; k++) begin
            @(negedge clk); pad_in = NPINS'($urandom);
        end
        wr(3'd2, 22'h3FFFFF); rd(3'd0); rd(3'd1); rd(3'd2);
        // R10: unused addresses
        cur_req = "R10"; rd(3'd5); rd(3'd6); rd(3'd7);
        // R6: sleep forces pads regardless of other inputs
        cur_req = "R6";
        @(negedge clk); sleep_enter = 1; @(negedge clk); sleep_enter = 0;
        for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            lane_en = NLANES'($urandom); per_out = '1; per_oe = NPINS'($urandom);
        end
        wr(3'd1, 22'h3FFFFF);
        // R8: clearing while asleep ignored
        cur_req = "R8"; wr(3'd4, 22'h000001); rd(3'd4);
        // R9: enter and wake together stays asleep
        cur_req = "R9";
        @(negedge clk); sleep_enter = 1; wake = 1;
        @(negedge clk); sleep_enter = 0; wake = 0; idle(2);
        // R8: clear in the wake cycle ignored
        cur_req = "R8";
        @(negedge clk); wake = 1; bus_wr = 1; bus_addr = 3'd4; bus_wdata = 22'h1;
        @(negedge clk); wake = 0; bus_wr = 0;
        // R7: hold keeps pads forced after wake
        cur_req = "R7"; idle(3); rd(3'd4);
        // R8: write zero no effect, write one releases
        cur_req = "R8"; wr(3'd4, 22'h3FFFFE); rd(3'd4); wr(3'd4, 22'h000001); idle(3);
        // R5 and R1: reset during hold keeps sleep directions, clears hold
        cur_req = "R5";
        @(negedge clk); sleep_enter = 1; @(negedge clk); sleep_enter = 0;
        wr(3'd3, 22'h0C3C3C); idle(2);
        @(negedge clk); rst_n = 0; idle(2); rst_n = 1;
        rd(3'd3);
        cur_req = "R1"; rd(3'd4); rd(3'd0); idle(2);
        finish_run();
    end
endmodule